// File: doc/BRIEF.md
# Vector Float Round-to-Integral Unit

This unit takes a 128-bit operand holding one, two or four IEEE-754 values. It rounds each value to an integral value and keeps the result in floating-point format. A shape select picks one of three layouts: a single double, a pair of doubles, or four singles. A rounding select picks one of four fixed directions, or it defers to the rounding mode that the control register currently holds. The unit never writes that control mode, so a fixed direction applies only to the operation that asks for it.

Every lane goes through its own copy of the rounding logic, and all lanes use the same effective mode. Signaling NaNs are quieted. Infinities, zeros, quiet NaNs and values that are already integral pass through unchanged. The per-lane flags are ORed into one status word. For the scalar shape only, the unit also produces a 5-bit result-class code. All outputs are registered and appear one clock after the input strobe.

Top module: `fp_round_int_unit`

## Requirements
- R1: `in_shape` 00 selects one double in bits 63:0, and result bits 127:64 are then zero whatever the input holds there. 01 selects two doubles, in bits 63:0 and 127:64. 10 and 11 select four singles, with lane i in bits 32i+31:32i.
- R2: `in_rsel` 0 means nearest-even, 1 toward minus infinity, 2 toward plus infinity, and 3 toward zero. Any value 4 to 7 uses `ctl_rmode`, which encodes 0 nearest-even, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity. `ctl_rmode` has no effect when `in_rsel` is below 4.
- R3: A finite lane value of magnitude at least one that has a fractional part is rounded to an integral value in the effective direction. Nearest-even breaks ties toward the even integer.
- R4: A nonzero value of magnitude below one, including a denormal, becomes a zero or a one in the effective direction. The result carries the input sign, so a negative value that rounds to zero gives minus zero.
- R5: Infinities, zeros, quiet NaNs and finite values whose exponent leaves no fractional bits pass through bit-exact and raise no flag.
- R6: A signaling NaN (exponent all ones, top fraction bit 0, fraction nonzero) comes out with its top fraction bit set, with sign and payload kept, and `out_snan_inv` is raised.
- R7: `out_inexact` reports a lane whose value changed in rounding, but only when `in_rsel` is 4 to 7. A fixed direction always gives 0.
- R8: For the scalar shape, `out_class` is the class of the result. The codes are: quiet NaN 10001, -inf 01001, +inf 00101, -normal 01000, +normal 00100, -denormal 11000, +denormal 10100, -zero 10010, +zero 00010. Vector shapes leave `out_class` unchanged.
- R9: `out_snan_inv` and `out_inexact` are the OR over all lanes of the selected shape.
- R10: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. Without `in_valid`, the result and flag outputs hold their values.
- R11: After reset, `out_valid`, `out_res`, both flags and `out_class` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_opnd | input | 128 | Packed operand lanes |
| in_shape | input | 2 | Lane layout select |
| in_rsel | input | 3 | Rounding direction select |
| ctl_rmode | input | 2 | Rounding mode currently held by the control register |
| out_valid | output | 1 | Result strobe |
| out_res | output | 128 | Packed rounded lanes |
| out_snan_inv | output | 1 | Signaling-NaN invalid flag |
| out_inexact | output | 1 | Inexact flag (current-mode only) |
| out_class | output | 5 | Result-class code of the last scalar operation |

## Verification
The result, both flags and the class code are all due in the single cycle after the strobe, because one register stage sits between the operand and every output. The bench drives each operation on a falling edge and drops the strobe on the next falling edge, then samples every output there. The rising edge between those two falling edges is the one that loads the result. The class check compares against a value the bench carries across operations, so a vector operation must leave the previous scalar class visible.

// File: rtl/fpri_pkg.sv
package fpri_pkg;

  // Effective rounding direction, same code as the control register field
  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  typedef enum logic [1:0] {
    SHP_SCALAR = 2'b00,
    SHP_PAIR   = 2'b01,
    SHP_QUAD   = 2'b10,
    SHP_QUAD_B = 2'b11
  } shape_e;

  localparam int DP_EW = 11;
  localparam int DP_FW = 52;
  localparam int SP_EW = 8;
  localparam int SP_FW = 23;

  // Increment decision for the kept integer part
  function automatic logic round_up(input rmode_e mode, input logic sgn,
                                    input logic gt_half, input logic eq_half,
                                    input logic odd, input logic nz);
    logic up;
    case (mode)
      RM_NEAR: up = gt_half || (eq_half && odd);
      RM_ZERO: up = 1'b0;
      RM_UP:   up = nz && !sgn;
      default: up = nz && sgn;
    endcase
    return up;
  endfunction

  // Five-bit result class of a double
  function automatic logic [4:0] class_dp(input logic [DP_EW+DP_FW:0] v);
    logic              s;
    logic [DP_EW-1:0]  e;
    logic [DP_FW-1:0]  f;
    logic [4:0]        c;
    s = v[DP_EW+DP_FW];
    e = v[DP_EW+DP_FW-1:DP_FW];
    f = v[DP_FW-1:0];
    if (e == '1) c = (f != '0) ? 5'b10001 : (s ? 5'b01001 : 5'b00101);
    else if (e == '0) begin
      if (f == '0) c = s ? 5'b10010 : 5'b00010;
      else         c = s ? 5'b11000 : 5'b10100;
    end else c = s ? 5'b01000 : 5'b00100;
    return c;
  endfunction

endpackage

// File: rtl/fpri_mode_sel.sv
module fpri_mode_sel
  import fpri_pkg::*;
(
  input  logic [2:0] rsel_i,
  input  logic [1:0] ctl_i,
  output rmode_e     mode_o,
  output logic       cur_o
);
  always_comb begin
    cur_o = rsel_i[2];
    case (rsel_i[1:0])
      2'd0:    mode_o = RM_NEAR;
      2'd1:    mode_o = RM_DOWN;
      2'd2:    mode_o = RM_UP;
      default: mode_o = RM_ZERO;
    endcase
    if (cur_o) mode_o = rmode_e'(ctl_i);
  end
endmodule

// File: rtl/fpri_lane.sv
module fpri_lane
  import fpri_pkg::*;
#(
  parameter int EW = 11,
  parameter int FW = 52
) (
  input  logic [EW+FW:0] op_i,
  input  rmode_e         mode_i,
  output logic [EW+FW:0] res_o,
  output logic           snan_o,
  output logic           inex_o
);
  localparam int W    = 1 + EW + FW;
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int SW   = FW + 2;

  logic          sgn;
  logic [EW-1:0] ex;
  logic [FW-1:0] fr;
  assign sgn = op_i[W-1];
  assign ex  = op_i[W-2:FW];
  assign fr  = op_i[FW-1:0];

  logic [SW-1:0] sig, ulp, mask, half, fbits, trunc, sum;
  logic          up;
  int            kk;

  always_comb begin
    sig    = {1'b0, 1'b1, fr};
    kk     = 1;
    ulp    = '0;
    mask   = '0;
    half   = '0;
    fbits  = '0;
    trunc  = '0;
    sum    = '0;
    up     = 1'b0;
    res_o  = op_i;
    snan_o = 1'b0;
    inex_o = 1'b0;
    if (ex == '1) begin
      if (fr != '0 && !fr[FW-1]) begin
        snan_o       = 1'b1;
        res_o[FW-1]  = 1'b1;
      end
    end else if (ex == '0 && fr == '0) begin
      res_o = op_i;
    end else if (ex >= EW'(BIAS + FW)) begin
      res_o = op_i;
    end else if (ex < EW'(BIAS)) begin
      inex_o = 1'b1;
      up = round_up(mode_i, sgn, (ex == EW'(BIAS - 1)) && (fr != '0),
                    1'b0, 1'b0, 1'b1);
      res_o = up ? {sgn, EW'(BIAS), {FW{1'b0}}} : {sgn, {(W-1){1'b0}}};
    end else begin
      kk     = BIAS + FW - int'(ex);
      ulp    = SW'(1) << kk;
      mask   = ulp - SW'(1);
      half   = ulp >> 1;
      fbits  = sig & mask;
      trunc  = sig & ~mask;
      inex_o = (fbits != '0);
      up = round_up(mode_i, sgn, fbits > half, fbits == half,
                    (sig & ulp) != '0, inex_o);
      sum = trunc + (up ? ulp : {SW{1'b0}});
      if (sum[FW+1]) res_o = {sgn, ex + EW'(1), {FW{1'b0}}};
      else           res_o = {sgn, ex, sum[FW-1:0]};
    end
  end
endmodule

// File: rtl/fp_round_int_unit.sv
module fp_round_int_unit
  import fpri_pkg::*;
#(
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [127:0]  in_opnd,
  input  logic [1:0]    in_shape,
  input  logic [2:0]    in_rsel,
  input  logic [1:0]    ctl_rmode,
  output logic          out_valid,
  output logic [127:0]  out_res,
  output logic          out_snan_inv,
  output logic          out_inexact,
  output logic [4:0]    out_class
);
  localparam int DPW = 1 + DP_EW + DP_FW;
  localparam int SPW = 1 + SP_EW + SP_FW;
  localparam int NDP = DW / DPW;
  localparam int NSP = DW / SPW;

  rmode_e eff_mode;
  logic   use_cur;

  fpri_mode_sel u_mode (
    .rsel_i (in_rsel),
    .ctl_i  (ctl_rmode),
    .mode_o (eff_mode),
    .cur_o  (use_cur)
  );

  logic [DW-1:0]  dp_vec, sp_vec;
  logic [NDP-1:0] dp_snan, dp_inex;
  logic [NSP-1:0] sp_snan, sp_inex;

  for (genvar g = 0; g < NDP; g++) begin : g_dp
    fpri_lane #(.EW(DP_EW), .FW(DP_FW)) u_lane (
      .op_i   (in_opnd[g*DPW +: DPW]),
      .mode_i (eff_mode),
      .res_o  (dp_vec[g*DPW +: DPW]),
      .snan_o (dp_snan[g]),
      .inex_o (dp_inex[g])
    );
  end

  for (genvar g = 0; g < NSP; g++) begin : g_sp
    fpri_lane #(.EW(SP_EW), .FW(SP_FW)) u_lane (
      .op_i   (in_opnd[g*SPW +: SPW]),
      .mode_i (eff_mode),
      .res_o  (sp_vec[g*SPW +: SPW]),
      .snan_o (sp_snan[g]),
      .inex_o (sp_inex[g])
    );
  end

  // Named events for the checks below
  logic [DW-1:0] nxt_res;
  logic          ev_snan, ev_inex_raw, ev_class_upd;
  logic [4:0]    nxt_class;

  always_comb begin
    case (shape_e'(in_shape))
      SHP_SCALAR: begin
        nxt_res     = DW'(dp_vec[DPW-1:0]);
        ev_snan     = dp_snan[0];
        ev_inex_raw = dp_inex[0];
      end
      SHP_PAIR: begin
        nxt_res     = dp_vec;
        ev_snan     = |dp_snan;
        ev_inex_raw = |dp_inex;
      end
      default: begin
        nxt_res     = sp_vec;
        ev_snan     = |sp_snan;
        ev_inex_raw = |sp_inex;
      end
    endcase
  end

  assign ev_class_upd = in_valid && (in_shape == SHP_SCALAR);
  assign nxt_class    = class_dp(dp_vec[DPW-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_res      <= '0;
      out_snan_inv <= 1'b0;
      out_inexact  <= 1'b0;
      out_class    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_res      <= nxt_res;
        out_snan_inv <= ev_snan;
        out_inexact  <= ev_inex_raw && use_cur;
      end
      if (ev_class_upd) out_class <= nxt_class;
    end
  end

  // R10
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_res) && $stable(out_inexact));

  // R7
  fixed_no_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_rsel[2]) |=> !out_inexact);

  // R8
  vec_class_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_shape != SHP_SCALAR) |=> $stable(out_class));

  // R6
  snan_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_snan) |=> out_snan_inv);

  // R4
  scalar_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_shape == SHP_SCALAR) |=> out_res[DPW-1] == $past(in_opnd[DPW-1]));

endmodule

// File: tb/fp_round_int_unit_bench.sv
module fp_round_int_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] in_opnd = '0;
  logic [1:0]   in_shape = '0;
  logic [2:0]   in_rsel = '0;
  logic [1:0]   ctl_rmode = '0;
  logic         out_valid;
  logic [127:0] out_res;
  logic         out_snan_inv;
  logic         out_inexact;
  logic [4:0]   out_class;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;
  logic [4:0] exp_cls = '0;
  logic [63:0] dv [24];

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_round_int_unit u_fp_round_int_unit (
    .clk, .rst_n, .in_valid, .in_opnd, .in_shape, .in_rsel, .ctl_rmode,
    .out_valid, .out_res, .out_snan_inv, .out_inexact, .out_class
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // direction: 0 nearest-even, 1 zero, 2 up, 3 down
  function automatic int eff_kind(input logic [2:0] rs, input logic [1:0] cm);
    if (rs >= 3'd4) return int'(cm);
    case (rs)
      3'd0: return 0;
      3'd1: return 3;
      3'd2: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic real rnd(input real x, input int kind);
    real f;
    real d;
    f = $floor(x);
    case (kind)
      0: begin
        d = x - f;
        if (d > 0.5) return f + 1.0;
        if (d < 0.5) return f;
        return ($floor(f / 2.0) * 2.0 == f) ? f : f + 1.0;
      end
      1: return (x < 0.0) ? $ceil(x) : f;
      2: return $ceil(x);
      default: return f;
    endcase
  endfunction

  function automatic logic [63:0] m_dp(input logic [63:0] b, input int kind,
                                       output bit sn, output bit ix);
    real x;
    real r;
    logic [63:0] o;
    sn = 1'b0; ix = 1'b0;
    if (b[62:52] == 11'h7FF) begin
      if (b[51:0] != 0 && !b[51]) begin sn = 1'b1; return b | (64'd1 << 51); end
      return b;
    end
    x = $bitstoreal(b);
    r = rnd(x, kind);
    ix = (r != x);
    if (r == 0.0) return {b[63], 63'd0};
    o = $realtobits(r);
    o[63] = b[63];
    return o;
  endfunction

  function automatic real sp2r(input logic [31:0] b);
    real v;
    if (b[30:23] == 8'd0) begin
      v = real'(b[22:0]);
      for (int i = 0; i < 149; i++) v = v / 2.0;
      if (b[31]) v = -v;
    end else v = $bitstoreal({b[31], 11'(b[30:23]) + 11'd896, b[22:0], 29'd0});
    return v;
  endfunction

  function automatic logic [31:0] m_sp(input logic [31:0] b, input int kind,
                                       output bit sn, output bit ix);
    real x;
    real r;
    logic [63:0] d;
    logic [10:0] e11;
    sn = 1'b0; ix = 1'b0;
    if (b[30:23] == 8'hFF) begin
      if (b[22:0] != 0 && !b[22]) begin sn = 1'b1; return b | (32'd1 << 22); end
      return b;
    end
    x = sp2r(b);
    r = rnd(x, kind);
    ix = (r != x);
    if (r == 0.0) return {b[31], 31'd0};
    d = $realtobits(r);
    e11 = d[62:52] - 11'd896;
    return {b[31], e11[7:0], d[51:29]};
  endfunction

  function automatic logic [4:0] cls(input logic [63:0] v);
    bit neg;
    neg = v[63];
    if (v[62:52] == 11'h7FF && v[51:0] != 0) return 5'b10001;
    if (v[62:52] == 11'h7FF) return neg ? 5'b01001 : 5'b00101;
    if (v[62:0] == 0) return neg ? 5'b10010 : 5'b00010;
    if (v[62:52] == 0) return neg ? 5'b11000 : 5'b10100;
    return neg ? 5'b01000 : 5'b00100;
  endfunction

  function automatic string tag_of(input logic [63:0] b, input logic [2:0] rs);
    real x;
    if (b[62:52] == 11'h7FF || b[62:0] == 0) return "R5";
    x = $bitstoreal(b);
    if (x < 1.0 && x > -1.0) return "R4";
    if (rs >= 3'd4) return "R2";
    return "R3";
  endfunction

  task automatic do_op(input logic [127:0] opnd, input logic [1:0] shp,
                       input logic [2:0] rs, input logic [1:0] cm, input string tag);
    logic [127:0] eres;
    bit esn, eix, s, x;
    int kind;
    kind = eff_kind(rs, cm);
    eres = '0; esn = 0; eix = 0;
    if (shp == 2'b00) begin
      eres[63:0] = m_dp(opnd[63:0], kind, esn, eix);
      exp_cls = cls(eres[63:0]);
    end else if (shp == 2'b01) begin
      for (int i = 0; i < 2; i++) begin
        eres[i*64 +: 64] = m_dp(opnd[i*64 +: 64], kind, s, x);
        esn |= s; eix |= x;
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        eres[i*32 +: 32] = m_sp(opnd[i*32 +: 32], kind, s, x);
        esn |= s; eix |= x;
      end
    end
    if (rs < 3'd4) eix = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_opnd = opnd; in_shape = shp; in_rsel = rs; ctl_rmode = cm;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, "R10", "out_valid", 128'(out_valid), 128'd1);
    chk(out_res === eres, tag, "result", out_res, eres);
    chk(out_snan_inv === esn, "R6/R9", "snan flag", 128'(out_snan_inv), 128'(esn));
    chk(out_inexact === eix, "R7", "inexact", 128'(out_inexact), 128'(eix));
    chk(out_class === exp_cls, "R8", "class", 128'(out_class), 128'(exp_cls));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    dv[0]  = 64'h7FF0000000000000;  dv[1]  = 64'hFFF0000000000000;
    dv[2]  = 64'h7FF8000000000001;  dv[3]  = 64'h7FF0000000000005;
    dv[4]  = 64'hFFF4000000000abc;  dv[5]  = 64'h0000000000000000;
    dv[6]  = 64'h8000000000000000;  dv[7]  = 64'h0000000000000001;
    dv[8]  = 64'h8000000000000001;  dv[9]  = 64'h0010000000000000;
    dv[10] = $realtobits(0.5);      dv[11] = $realtobits(1.5);
    dv[12] = $realtobits(2.5);      dv[13] = $realtobits(-0.5);
    dv[14] = $realtobits(-1.5);     dv[15] = $realtobits(-2.5);
    dv[16] = $realtobits(0.3);      dv[17] = $realtobits(-0.7);
    dv[18] = $realtobits(2.75);     dv[19] = $realtobits(-2.25);
    dv[20] = $realtobits(3.0);      dv[21] = $realtobits(4503599627370495.5);
    dv[22] = $realtobits(1.0e300);  dv[23] = $realtobits(-7.5);

    repeat (3) @(negedge clk);
    // R11 reset state
    chk(out_valid === 1'b0, "R11", "valid in reset", 128'(out_valid), 128'd0);
    chk(out_res === '0, "R11", "result in reset", out_res, 128'd0);
    chk({out_snan_inv, out_inexact} === 2'b00, "R11", "flags in reset",
        128'({out_snan_inv, out_inexact}), 128'd0);
    chk(out_class === 5'd0, "R11", "class in reset", 128'(out_class), 128'd0);
    rst_n = 1'b1;

    // Scalar sweep; upper half holds junk that must not appear (R1)
    for (int i = 0; i < 24; i++)
      for (int m = 0; m < 8; m++) begin
        logic [2:0] rs;
        logic [1:0] cm;
        rs = (m < 4) ? 3'(m) : ((m == 7) ? 3'd7 : 3'd4);
        cm = (m < 4) ? 2'(3 - m) : 2'(m - 4);
        do_op({dv[(i + 3) % 24], dv[i]}, 2'b00, rs, cm, tag_of(dv[i], rs));
      end

    // R10: idle cycle holds outputs and drops valid
    held = out_res;
    @(negedge clk);
    chk(out_valid === 1'b0, "R10", "valid after idle", 128'(out_valid), 128'd0);
    chk(out_res === held, "R10", "result held", out_res, held);

    // Pair-of-doubles sweep (R1, R9)
    for (int i = 0; i < 24; i++)
      for (int m = 0; m < 8; m++) begin
        logic [2:0] rs;
        logic [1:0] cm;
        rs = (m < 4) ? 3'(m) : 3'd5;
        cm = (m < 4) ? 2'(m) : 2'(m - 4);
        do_op({dv[(i + 7) % 24], dv[i]}, 2'b01, rs, cm, "R1");
      end

    // Four-singles sweep over exponents and fractions (R1, R3, R4)
    for (int e = 116; e < 154; e++)
      for (int fi = 0; fi < 6; fi++)
        for (int m = 0; m < 8; m++) begin
          logic [22:0] f;
          logic [7:0]  eb;
          logic [2:0]  rs;
          logic [1:0]  cm;
          case (fi)
            0: f = 23'd0;       1: f = 23'd1;
            2: f = 23'h400000;  3: f = 23'h200000;
            4: f = 23'h7FFFFF;  default: f = 23'h0C0000;
          endcase
          eb = 8'(e);
          rs = (m < 4) ? 3'(m) : 3'd6;
          cm = (m < 4) ? 2'd0 : 2'(m - 4);
          do_op({1'b1, eb, f | 23'd1, 1'b0, eb, f ^ 23'h155555,
                 1'b1, eb, f, 1'b0, eb, f}, (m[0] ? 2'b11 : 2'b10), rs, cm, "R1");
        end

    // Singles specials: sNaN in one lane only, denormal, inf, qNaN (R6, R9, R5)
    for (int m = 0; m < 8; m++)
      do_op({32'h7F800000, 32'h7FC00011, 32'h00000005, 32'hFF800123},
            2'b10, 3'(m), 2'(m % 4), "R6");
    do_op({32'h3F800000, 32'h80000000, 32'h4B000001, 32'h3FC00000},
          2'b10, 3'd4, 2'd1, "R5");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule